// File: doc/BRIEF.md
# Overlay Window Alpha Compositor

This block places one layer of pixels over a background stream inside a rectangular window of the output frame. It walks the output frame in raster order, one pixel per valid cycle, and at each position decides whether the layer is visible. Inside the window the layer and background are mixed with an alpha coefficient. Outside the window, or when the layer is off, the background passes through unchanged.

The alpha source follows from the layer's pixel format and its global alpha value. A format that carries its own alpha uses the pixel alpha when the global value is full scale, and uses the product of pixel and global alpha otherwise. An opaque format uses the global alpha alone. Two coefficient selectors choose the weight applied to the layer and to the background. The layer is picked from several source channels by a select code that counts channels from one.

Top module: `ovl_compositor`

## Requirements
- R1: During reset and until the first valid pixel, `valid_o`, `eof_o`, `pix_o`, `pix_x_o` and `pix_y_o` are all zero.
- R2: `win_start_i` and `win_end_i` hold x in bits [31:16] and y in bits [15:0]. The end corner is inclusive, so a pixel at (x,y) is inside the window when x0<=x<=x1 and y0<=y<=y1.
- R3: When the pixel is outside the window, `layer_en_i` is 0, or `src_sel_i` is 0 or greater than NUM_SRC, `pix_o` equals the background pixel.
- R4: Format codes 6, 7, 8 and 9 on `fmt_i` carry per-pixel alpha. Codes 0 to 5 are opaque, and any alpha bits in their input words have no effect.
- R5: `mode_o` is 0 (global alpha) for opaque formats. It is 1 (pixel alpha) for alpha formats when `glb_alpha_i` is 255, and 2 (combined alpha) for alpha formats when `glb_alpha_i` is below 255.
- R6: In combined mode the effective alpha is round(pa*ga/255), where pa is the pixel alpha and ga is the global alpha.
- R7: `top_sel_i` and `und_sel_i` use these codes: 0 gives a coefficient of 0, 1 gives 255, 2 gives alpha, and 3 gives 255-alpha. Each 8-bit output component is round((ct*top + cu*under)/255), clamped to 255.
- R8: `src_sel_i` = k with 1<=k<=NUM_SRC selects layer word k-1 of `src_pix_i`, which sits at bits [32k-1:32(k-1)].
- R9: `out_size_i` holds width-1 in [31:16] and height-1 in [15:0]. Valid pixels take coordinates x = 0..W-1 along each line and y = 0..H-1 down the frame. `eof_o` marks the pixel at (W-1, H-1), after which the coordinates return to (0,0).
- R10: Results appear one cycle after `pix_valid_i`. A cycle without `pix_valid_i` gives `valid_o` = 0 and does not move the coordinates.
- R11: A layer word carries alpha in [31:24] and R, G, B in [23:16], [15:8] and [7:0]. The background and output words use the same layout in 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| out_size_i | input | 32 | Output frame size minus one, packed as {w-1, h-1} |
| win_start_i | input | 32 | Window start corner, packed as {x0, y0} |
| win_end_i | input | 32 | Inclusive window end corner, packed as {x1, y1} |
| layer_en_i | input | 1 | Layer enable |
| src_sel_i | input | 3 | Source channel number plus one; 0 means no channel |
| glb_alpha_i | input | 8 | Global alpha |
| fmt_i | input | 4 | Layer pixel format code |
| top_sel_i | input | 2 | Coefficient select for the layer |
| und_sel_i | input | 2 | Coefficient select for the background |
| src_pix_i | input | 128 | Layer words from all source channels |
| bg_pix_i | input | 24 | Background pixel |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_x_o | output | 16 | x coordinate of the output pixel |
| pix_y_o | output | 16 | y coordinate of the output pixel |
| mode_o | output | 2 | Derived alpha mode |
| pix_o | output | 24 | Composited pixel |
| valid_o | output | 1 | Output pixel valid |
| eof_o | output | 1 | Last pixel of the frame |

## Verification
The hardest cases to reach from the ports are the window edges and the frame wrap. Both depend on a raster position that only moves with valid pixels, so the bench keeps its own coordinate counter. It runs a small 4x2 frame with a window of one row and two columns, so that every inclusive edge, the line wrap and the end-of-frame marker all occur within eight pixels. An idle cycle placed mid-frame shows that stalls do not advance the position. The rounding boundaries of the combined alpha and the saturating sum are reached through table rows with extreme alpha and coefficient settings.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {AM_GLOBAL = 2'd0, AM_PIXEL = 2'd1, AM_BOTH = 2'd2} amode_e;
  typedef enum logic [1:0] {CF_ZERO = 2'd0, CF_ONE = 2'd1, CF_ALPHA = 2'd2, CF_INV = 2'd3} coef_e;

  function automatic logic fmt_has_alpha(input logic [3:0] fmt);
    return (fmt >= 4'd6) && (fmt <= 4'd9);
  endfunction

  // round(v/255); inputs at or above 255*255 clamp to 255
  function automatic logic [7:0] div255_rnd(input logic [16:0] v);
    logic [16:0] t;
    logic [16:0] s;
    if (v >= 17'd65025) return 8'hff;
    t = v + 17'd128;
    s = t + (t >> 8);
    return s[15:8];
  endfunction

  function automatic logic [7:0] coef_val(input logic [1:0] sel, input logic [7:0] a);
    case (sel)
      CF_ZERO:  return 8'd0;
      CF_ONE:   return 8'd255;
      CF_ALPHA: return a;
      default:  return 8'd255 - a;
    endcase
  endfunction
endpackage

// File: rtl/ovl_raster.sv
module ovl_raster #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [CW-1:0] wm1_i,
  input  logic [CW-1:0] hm1_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          last_o
);
  logic [CW-1:0] x_q, y_q;
  logic x_end, y_end;

  assign x_end  = (x_q >= wm1_i);
  assign y_end  = (y_q >= hm1_i);
  assign last_o = x_end && y_end;
  assign x_o    = x_q;
  assign y_o    = y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_i) begin
      if (x_end) begin
        x_q <= '0;
        y_q <= y_end ? '0 : y_q + 1'b1;
      end else begin
        x_q <= x_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ovl_alpha.sv
module ovl_alpha
  import ovl_pkg::*;
(
  input  logic [3:0] fmt_i,
  input  logic [7:0] glb_i,
  input  logic [7:0] pix_a_i,
  output logic [1:0] mode_o,
  output logic [7:0] alpha_o
);
  logic [15:0] prod;
  amode_e mode;

  assign prod = pix_a_i * glb_i;

  always_comb begin
    if (!fmt_has_alpha(fmt_i))  mode = AM_GLOBAL;
    else if (glb_i == 8'hff)    mode = AM_PIXEL;
    else                        mode = AM_BOTH;
    case (mode)
      AM_PIXEL: alpha_o = pix_a_i;
      AM_BOTH:  alpha_o = div255_rnd({1'b0, prod});
      default:  alpha_o = glb_i;
    endcase
  end

  assign mode_o = mode;
endmodule

// File: rtl/ovl_blend.sv
module ovl_blend
  import ovl_pkg::*;
#(
  parameter int NCOMP = 3
) (
  input  logic [7:0]         alpha_i,
  input  logic [1:0]         top_sel_i,
  input  logic [1:0]         und_sel_i,
  input  logic [NCOMP*8-1:0] top_i,
  input  logic [NCOMP*8-1:0] und_i,
  output logic [NCOMP*8-1:0] out_o
);
  logic [7:0] ct, cu;

  assign ct = coef_val(top_sel_i, alpha_i);
  assign cu = coef_val(und_sel_i, alpha_i);

  for (genvar k = 0; k < NCOMP; k++) begin : g_comp
    logic [15:0] pt, pu;
    logic [16:0] sum;
    assign pt  = ct * top_i[k*8 +: 8];
    assign pu  = cu * und_i[k*8 +: 8];
    assign sum = {1'b0, pt} + {1'b0, pu};
    assign out_o[k*8 +: 8] = div255_rnd(sum);
  end
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
  import ovl_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int PACK_W  = 32,
  parameter int PIX_W   = 32,
  localparam int CW     = PACK_W / 2,
  localparam int SELW   = $clog2(NUM_SRC + 1),
  localparam int RGB_W  = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PACK_W-1:0]        out_size_i,
  input  logic [PACK_W-1:0]        win_start_i,
  input  logic [PACK_W-1:0]        win_end_i,
  input  logic                     layer_en_i,
  input  logic [SELW-1:0]          src_sel_i,
  input  logic [7:0]               glb_alpha_i,
  input  logic [3:0]               fmt_i,
  input  logic [1:0]               top_sel_i,
  input  logic [1:0]               und_sel_i,
  input  logic [NUM_SRC*PIX_W-1:0] src_pix_i,
  input  logic [RGB_W-1:0]         bg_pix_i,
  input  logic                     pix_valid_i,
  output logic [CW-1:0]            pix_x_o,
  output logic [CW-1:0]            pix_y_o,
  output logic [1:0]               mode_o,
  output logic [RGB_W-1:0]         pix_o,
  output logic                     valid_o,
  output logic                     eof_o
);
  logic [CW-1:0] cur_x, cur_y;
  logic          ras_last;
  logic [PIX_W-1:0] sel_pix;
  logic          ch_ok, in_win, hit;
  logic [7:0]    alpha;
  logic [RGB_W-1:0] mix;

  ovl_raster #(.CW(CW)) u_ras (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (pix_valid_i),
    .wm1_i  (out_size_i[PACK_W-1:CW]),
    .hm1_i  (out_size_i[CW-1:0]),
    .x_o    (cur_x),
    .y_o    (cur_y),
    .last_o (ras_last)
  );

  assign ch_ok = (src_sel_i != '0) && (int'(src_sel_i) <= NUM_SRC);

  always_comb begin
    sel_pix = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (int'(src_sel_i) == i + 1) sel_pix = src_pix_i[i*PIX_W +: PIX_W];
  end

  assign in_win = (cur_x >= win_start_i[PACK_W-1:CW]) && (cur_x <= win_end_i[PACK_W-1:CW]) &&
                  (cur_y >= win_start_i[CW-1:0])      && (cur_y <= win_end_i[CW-1:0]);
  assign hit = layer_en_i && ch_ok && in_win;

  ovl_alpha u_alpha (
    .fmt_i   (fmt_i),
    .glb_i   (glb_alpha_i),
    .pix_a_i (sel_pix[31:24]),
    .mode_o  (mode_o),
    .alpha_o (alpha)
  );

  ovl_blend #(.NCOMP(3)) u_blend (
    .alpha_i   (alpha),
    .top_sel_i (top_sel_i),
    .und_sel_i (und_sel_i),
    .top_i     (sel_pix[RGB_W-1:0]),
    .und_i     (bg_pix_i),
    .out_o     (mix)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
      pix_x_o <= '0;
      pix_y_o <= '0;
    end else begin
      valid_o <= pix_valid_i;
      eof_o   <= pix_valid_i && ras_last;
      if (pix_valid_i) begin
        pix_o   <= hit ? mix : bg_pix_i;
        pix_x_o <= cur_x;
        pix_y_o <= cur_y;
      end
    end
  end

  // R3
  bg_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !layer_en_i) |=> (pix_o == $past(bg_pix_i)));

  // R9
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && eof_o && pix_valid_i) |=> (pix_x_o == '0 && pix_y_o == '0));

  // R5
  pix_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == AM_PIXEL) |-> (alpha == sel_pix[31:24]));

  // R4
  opaque_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i < 4'd6) |-> (mode_o == AM_GLOBAL));

  // R7
  top_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && hit && top_sel_i == CF_ONE && und_sel_i == CF_ZERO)
      |=> (pix_o == $past(sel_pix[RGB_W-1:0])));
endmodule

// File: tb/sim_ovl_compositor.sv
`timescale 1ns/1ps
module sim_ovl_compositor;
  localparam int NS = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] out_size, win_s, win_e;
  logic        en;
  logic [2:0]  sel;
  logic [7:0]  ga;
  logic [3:0]  fmt;
  logic [1:0]  tsel, usel;
  logic [31:0] src [NS];
  logic [NS*32-1:0] src_flat;
  logic [23:0] bg;
  logic        vin;
  logic [15:0] xo, yo;
  logic [1:0]  mode;
  logic [23:0] po;
  logic        vo, eo;

  int total = 0, bad = 0, ex = 0, ey = 0;
  bit done = 0;

  always #10 clk = ~clk;

  for (genvar i = 0; i < NS; i++) begin : g_src
    assign src_flat[i*32 +: 32] = src[i];
  end

  ovl_compositor u0 (
    .clk_i(clk), .rst_ni(rst_n), .out_size_i(out_size), .win_start_i(win_s), .win_end_i(win_e),
    .layer_en_i(en), .src_sel_i(sel), .glb_alpha_i(ga), .fmt_i(fmt), .top_sel_i(tsel),
    .und_sel_i(usel), .src_pix_i(src_flat), .bg_pix_i(bg), .pix_valid_i(vin),
    .pix_x_o(xo), .pix_y_o(yo), .mode_o(mode), .pix_o(po), .valid_o(vo), .eof_o(eo)
  );

  // fmt, ga, tsel, usel, layer word, bg, expected mode
  typedef struct packed {
    logic [3:0] f; logic [7:0] g; logic [1:0] t; logic [1:0] u;
    logic [31:0] lp; logic [23:0] b; logic [1:0] m;
  } vec_t;
  localparam vec_t VT [10] = '{
    '{4'd2, 8'd255, 2'd2, 2'd3, 32'h00112233, 24'h445566, 2'd0},
    '{4'd2, 8'd128, 2'd2, 2'd3, 32'h00ff8010, 24'h10f020, 2'd0},
    '{4'd8, 8'd255, 2'd2, 2'd3, 32'h80c0c0c0, 24'h404040, 2'd1},
    '{4'd6, 8'd100, 2'd2, 2'd3, 32'hc8a0b0e0, 24'h203040, 2'd2},
    '{4'd9, 8'd0,   2'd2, 2'd3, 32'hff123456, 24'h789abc, 2'd2},
    '{4'd4, 8'd60,  2'd2, 2'd3, 32'hffffffff, 24'h000000, 2'd0},
    '{4'd2, 8'd255, 2'd1, 2'd1, 32'h00f0f0f0, 24'h808080, 2'd0},
    '{4'd2, 8'd200, 2'd0, 2'd0, 32'h00abcdef, 24'h123456, 2'd0},
    '{4'd0, 8'd0,   2'd2, 2'd3, 32'h00ffffff, 24'h0a0b0c, 2'd0},
    '{4'd7, 8'd254, 2'd3, 2'd2, 32'h00ffeedd, 24'h336699, 2'd2}
  };

  function automatic int coef(int s, int a);
    case (s)
      0: return 0;
      1: return 255;
      2: return a;
      default: return 255 - a;
    endcase
  endfunction

  function automatic logic [23:0] model(int x, int y, logic [23:0] b);
    logic [31:0] lp;
    int pa, a, r, x0, y0, x1, y1;
    logic [23:0] res;
    x0 = int'(win_s[31:16]); y0 = int'(win_s[15:0]);
    x1 = int'(win_e[31:16]); y1 = int'(win_e[15:0]);
    if (!en || sel == 0 || sel > NS || x < x0 || x > x1 || y < y0 || y > y1) return b;
    lp = src[sel-1];
    pa = int'(lp[31:24]);
    if (fmt >= 6 && fmt <= 9) a = (ga < 255) ? (pa * int'(ga) * 2 + 255) / 510 : pa;
    else a = int'(ga);
    for (int k = 0; k < 3; k++) begin
      r = ((coef(int'(tsel), a) * int'(lp[k*8 +: 8]) + coef(int'(usel), a) * int'(b[k*8 +: 8])) * 2 + 255) / 510;
      if (r > 255) r = 255;
      res[k*8 +: 8] = r[7:0];
    end
    return res;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // drive one valid pixel and check it one cycle later
  task automatic pixel(string req, logic [23:0] b);
    logic [23:0] e;
    int w, h;
    w = int'(out_size[31:16]) + 1; h = int'(out_size[15:0]) + 1;
    bg = b; vin = 1;
    e = model(ex, ey, b);
    @(negedge clk);
    vin = 0;
    chk(req, {8'd0, po}, {8'd0, e});
    chk("R10 valid", {31'd0, vo}, 32'd1);
    chk("R9 coord", {xo, yo}, {ex[15:0], ey[15:0]});
    chk("R9 eof", {31'd0, eo}, {31'd0, (ex == w - 1 && ey == h - 1)});
    if (ex == w - 1) begin ex = 0; ey = (ey == h - 1) ? 0 : ey + 1; end
    else ex++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    out_size = {16'd3, 16'd1}; win_s = 0; win_e = {16'd3, 16'd1};
    en = 1; sel = 1; ga = 255; fmt = 2; tsel = 2; usel = 3; bg = 0; vin = 0;
    for (int i = 0; i < NS; i++) src[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 during reset", {xo, yo}, 0);
    chk("R1 during reset", {7'd0, vo, eo, po}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {7'd0, vo, eo, po}, 0);

    // table walk: R4 R5 R6 R7 R11
    for (int i = 0; i < 10; i++) begin
      fmt = VT[i].f; ga = VT[i].g; tsel = VT[i].t; usel = VT[i].u;
      src[0] = VT[i].lp; src[1] = ~VT[i].lp;
      #1;
      chk("R5 mode", {30'd0, mode}, {30'd0, VT[i].m});
      pixel("R7 blend", VT[i].b);
    end

    // partial window, inclusive corners: R2 R3
    while (!(ex == 0 && ey == 0)) pixel("R9 align", 24'h111111);
    fmt = 2; ga = 255; tsel = 1; usel = 0; src[0] = 32'h00aabbcc;
    win_s = {16'd1, 16'd1}; win_e = {16'd2, 16'd1};
    for (int i = 0; i < 8; i++) pixel("R2 window", 24'h010203);

    // R10 stall: idle cycle does not move coordinates
    pixel("R10 pre", 24'h050505);
    @(negedge clk);
    chk("R10 idle", {31'd0, vo}, 0);
    pixel("R10 post", 24'h060606);

    // R3 layer disabled, channel zero, channel out of range
    win_s = 0; win_e = {16'd3, 16'd1};
    en = 0; pixel("R3 disabled", 24'h0f0e0d);
    en = 1; sel = 0; pixel("R3 no channel", 24'h0c0b0a);
    sel = 5; pixel("R3 bad channel", 24'h090807);

    // R8 channel select picks the right word
    src[0] = 32'h00111111; src[1] = 32'h00222222; src[2] = 32'h00333333; src[3] = 32'h00444444;
    sel = 3; pixel("R8 ch3", 24'h000000);
    chk("R8 value", {8'd0, po}, 32'h00333333);
    sel = 4; pixel("R8 ch4", 24'h000000);

    // R4 opaque format ignores alpha bits
    fmt = 5; ga = 255; tsel = 2; usel = 3; sel = 1; src[0] = 32'h00405060;
    pixel("R4 opaque a0", 24'h998877);
    chk("R4 value", {8'd0, po}, 32'h00405060);
    src[0] = 32'h7f405060;
    pixel("R4 opaque a7f", 24'h998877);
    chk("R4 value", {8'd0, po}, 32'h00405060);

    // R6 combined rounding corner: pa=255 ga=1
    fmt = 8; ga = 1; src[0] = 32'hff0000ff;
    #1 chk("R6 mode", {30'd0, mode}, 32'd2);
    pixel("R6 combined", 24'hff0000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule